// File: doc/BRIEF.md
# Angle PWM Frame Encoder

This block turns a 12-bit angle and an error status into a repeating pulse-width frame of fixed length. A programmable divider makes a slow PWM clock from the system clock, and one frame lasts 4119 of those PWM clocks. Each frame has four parts. A 12-clock start section is always high. It is followed by a 4-clock error-indication section, a 4095-clock data section and an 8-clock low tail. In normal operation the error-indication clocks are high, and the data section stays high for as many clocks as the angle value. When the error status is set, only the start section is high, which gives a duty cycle of about 0.3 percent.

The angle fed to the block is the uncompensated measurement. The block samples the angle and the error status once, at the start of each frame, so a frame never mixes two values. An enable input switches the encoder on. A select input chooses which of two shared output pins carries the frame, the W pin or the I pin. The pin that does not carry the frame passes through its normal function signal. While the encoder is disabled, both pins carry their normal functions and the frame generator is held idle. Enabling it starts a fresh frame.

Top module: `pwm_angle_frame`

## Requirements
- R1: One frame lasts exactly 4119 PWM clocks, each PWM clock lasts DIV system clocks, and frames repeat back to back while the block is enabled.
- R2: With the error input low, the frame is high for 16 + angle PWM clocks from its start and low for the rest. The 16 clocks are the 12 start clocks and the 4 error-indication clocks.
- R3: With the error input high, the frame is high for exactly 12 PWM clocks. The error-indication clocks and the whole data section are low.
- R4: The angle and error inputs are sampled only at the start of a frame. A change during a frame takes effect in the following frame.
- R5: While pwm_en_i is low, w_o follows w_func_i and i_o follows idx_func_i, and the internal frame output stays low.
- R6: With pwm_en_i high and pwm_sel_i = 0, w_o carries the frame and i_o follows idx_func_i. With pwm_sel_i = 1, i_o carries the frame and w_o follows w_func_i.
- R7: When pwm_en_i rises, a fresh frame starts. The selected pin goes high on the second system clock edge after enable is first sampled high.
- R8: While rst_ni is low, the frame output is low even if the block is enabled, and i_o follows idx_func_i when pwm_sel_i = 0.
- R9: The angle extremes are encoded exactly. Angle 0 gives 16 high PWM clocks, and angle 4095 gives 4111 high PWM clocks followed by 8 low clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_en_i | input | 1 | Frame encoder enable |
| pwm_sel_i | input | 1 | Pin that carries the frame: 0 = W pin, 1 = I pin |
| angle_i | input | ANGLE_W | Uncompensated angle to encode |
| err_i | input | 1 | Error status to encode |
| w_func_i | input | 1 | Normal W-pin function (commutation) |
| idx_func_i | input | 1 | Normal I-pin function (index) |
| w_o | output | 1 | W pin |
| i_o | output | 1 | I pin |

## Verification
A position counter that is off by one or wraps at the wrong value changes the frame period. The error shows in the first full frame, as a rise-to-rise distance other than 4119 PWM clocks. A wrong sampling register shows within one frame, either as a high time that follows a mid-frame input change or as a high time that ignores the value present at the frame start. A bad error or section decode shows in the first frame as a high time other than 12 or 16 + angle PWM clocks. A routing error shows on the pin in the same cycle.

// File: rtl/pwm_frame_pkg.sv
package pwm_frame_pkg;
  typedef enum logic [1:0] {
    SEC_INIT,
    SEC_ERR,
    SEC_DATA,
    SEC_TAIL
  } frame_sec_e;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int DIV = 44
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick_o = run_i;
    end else begin : g_div
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_q <= '0;
        else if (!run_i)                      cnt_q <= '0;
        else if (cnt_q == CNT_W'(DIV - 1))    cnt_q <= '0;
        else                                  cnt_q <= cnt_q + CNT_W'(1);
      end
      assign tick_o = run_i && (cnt_q == CNT_W'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/pwm_frame_pos.sv
module pwm_frame_pos #(
  parameter int FRAME_LEN = 4119,
  parameter int POS_W     = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_o,
  output logic             active_o,
  output logic             start_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic at_last;
  assign at_last = (pos_o == LAST);
  // load strobe: first cycle after enable, or wrap into the next frame
  assign start_o = run_i && (!active_o || (tick_i && at_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o    <= '0;
      active_o <= 1'b0;
    end else if (!run_i) begin
      pos_o    <= '0;
      active_o <= 1'b0;
    end else if (!active_o) begin
      pos_o    <= '0;
      active_o <= 1'b1;
    end else if (tick_i) begin
      pos_o    <= at_last ? '0 : pos_o + POS_W'(1);
    end
  end
endmodule

// File: rtl/pwm_frame_shape.sv
module pwm_frame_shape
  import pwm_frame_pkg::*;
#(
  parameter int ANGLE_W  = 12,
  parameter int POS_W    = 13,
  parameter int INIT_LEN = 12,
  parameter int ERR_LEN  = 4,
  parameter int DATA_LEN = 4095
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               active_i,
  input  logic               start_i,
  input  logic [POS_W-1:0]   pos_i,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               err_i,
  output logic [ANGLE_W-1:0] ang_q_o,
  output logic               err_q_o,
  output logic               pwm_o
);
  localparam int ERR_END  = INIT_LEN + ERR_LEN;
  localparam int DATA_END = ERR_END + DATA_LEN;

  frame_sec_e       sec;
  logic [POS_W-1:0] data_off;
  logic             level;

  always_comb begin
    if (pos_i < POS_W'(INIT_LEN))      sec = SEC_INIT;
    else if (pos_i < POS_W'(ERR_END))  sec = SEC_ERR;
    else if (pos_i < POS_W'(DATA_END)) sec = SEC_DATA;
    else                               sec = SEC_TAIL;
  end

  assign data_off = pos_i - POS_W'(ERR_END);

  always_comb begin
    unique case (sec)
      SEC_INIT: level = 1'b1;
      SEC_ERR:  level = !err_q_o;
      SEC_DATA: level = !err_q_o && (data_off < POS_W'(ang_q_o));
      default:  level = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ang_q_o <= '0;
      err_q_o <= 1'b0;
      pwm_o   <= 1'b0;
    end else begin
      if (start_i) begin
        ang_q_o <= angle_i;
        err_q_o <= err_i;
      end
      pwm_o <= run_i && active_i && level;
    end
  end
endmodule

// File: rtl/pwm_angle_frame.sv
module pwm_angle_frame #(
  parameter int DIV      = 44,
  parameter int ANGLE_W  = 12,
  parameter int INIT_LEN = 12,
  parameter int ERR_LEN  = 4,
  parameter int TAIL_LEN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwm_en_i,
  input  logic               pwm_sel_i,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               err_i,
  input  logic               w_func_i,
  input  logic               idx_func_i,
  output logic               w_o,
  output logic               i_o
);
  localparam int DATA_LEN  = (1 << ANGLE_W) - 1;
  localparam int FRAME_LEN = INIT_LEN + ERR_LEN + DATA_LEN + TAIL_LEN;
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic               tick;
  logic               active;
  logic               start;
  logic [POS_W-1:0]   pos_q;
  logic [ANGLE_W-1:0] ang_q;
  logic               err_q;
  logic               pwm_q;

  pwm_tick_div #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (pwm_en_i && active),
    .tick_o (tick)
  );

  pwm_frame_pos #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (pwm_en_i),
    .tick_i   (tick),
    .pos_o    (pos_q),
    .active_o (active),
    .start_o  (start)
  );

  pwm_frame_shape #(
    .ANGLE_W  (ANGLE_W),
    .POS_W    (POS_W),
    .INIT_LEN (INIT_LEN),
    .ERR_LEN  (ERR_LEN),
    .DATA_LEN (DATA_LEN)
  ) u_shape (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (pwm_en_i),
    .active_i (active),
    .start_i  (start),
    .pos_i    (pos_q),
    .angle_i  (angle_i),
    .err_i    (err_i),
    .ang_q_o  (ang_q),
    .err_q_o  (err_q),
    .pwm_o    (pwm_q)
  );

  // pin routing: the pin not carrying the frame keeps its own function
  always_comb begin
    w_o = w_func_i;
    i_o = idx_func_i;
    if (pwm_en_i) begin
      if (pwm_sel_i) i_o = pwm_q;
      else           w_o = pwm_q;
    end
  end
endmodule

// File: rtl/pwm_frame_chk.sv
module pwm_frame_chk #(
  parameter int ANGLE_W   = 12,
  parameter int FRAME_LEN = 4119,
  parameter int POS_W     = 13,
  parameter int INIT_LEN  = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en,
  input logic               sel,
  input logic               w_func,
  input logic               idx_func,
  input logic               w_pin,
  input logic               i_pin,
  input logic               tick,
  input logic               active,
  input logic [POS_W-1:0]   pos,
  input logic [ANGLE_W-1:0] ang_q,
  input logic               err_q,
  input logic               pwm
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  p_pos_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos <= LAST);

  p_pos_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && active && tick && pos != LAST) |=> (pos == $past(pos) + POS_W'(1)));

  p_pos_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && active && tick && pos == LAST) |=> (pos == '0));

  p_err_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && err_q && pos >= POS_W'(INIT_LEN)) |=> !pwm);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !(tick && pos == LAST)) |=> ($stable(ang_q) && $stable(err_q)));

  p_off_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !pwm);

  p_pass_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (w_pin == w_func && i_pin == idx_func));

  p_route_i_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && sel) |-> (i_pin == pwm && w_pin == w_func));

  p_route_w_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !sel) |-> (w_pin == pwm && i_pin == idx_func));

  p_fresh_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !active) |=> (active && pos == '0));
endmodule

bind pwm_angle_frame pwm_frame_chk #(
  .ANGLE_W   (ANGLE_W),
  .FRAME_LEN (FRAME_LEN),
  .POS_W     (POS_W),
  .INIT_LEN  (INIT_LEN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en       (pwm_en_i),
  .sel      (pwm_sel_i),
  .w_func   (w_func_i),
  .idx_func (idx_func_i),
  .w_pin    (w_o),
  .i_pin    (i_o),
  .tick     (tick),
  .active   (active),
  .pos      (pos_q),
  .ang_q    (ang_q),
  .err_q    (err_q),
  .pwm      (pwm_q)
);

// File: tb/sim_pwm_angle_frame.sv
module sim_pwm_angle_frame;
  localparam int DIV   = 2;
  localparam int FRAME = 4119;
  localparam int PER   = FRAME * DIV;
  localparam int LIM   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwm_en_i = 1'b0;
  logic        pwm_sel_i = 1'b0;
  logic [11:0] angle_i = '0;
  logic        err_i = 1'b0;
  logic        w_func_i = 1'b0;
  logic        idx_func_i = 1'b0;
  logic        w_o, i_o;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwm_angle_frame #(.DIV(DIV)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_en_i(pwm_en_i), .pwm_sel_i(pwm_sel_i),
    .angle_i(angle_i), .err_i(err_i), .w_func_i(w_func_i), .idx_func_i(idx_func_i),
    .w_o(w_o), .i_o(i_o)
  );

  function automatic logic pin();
    return pwm_sel_i ? i_o : w_o;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // restart the encoder with new values; the pin must rise on the 2nd sample
  task automatic start_frame(input logic sel, input logic [11:0] ang, input logic err);
    logic s1, s2;
    @(negedge clk_i);
    pwm_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    pwm_sel_i = sel; angle_i = ang; err_i = err;
    pwm_en_i = 1'b1;
    @(negedge clk_i); s1 = pin();
    @(negedge clk_i); s2 = pin();
    check(s1 == 1'b0 && s2 == 1'b1, "R7 fresh frame rise", {s1, s2}, 2'b01);
  endtask

  // measure one frame from a rise; optionally change inputs after chg_at high samples
  task automatic measure(input bit at_rise, input int chg_at, input logic [11:0] c_ang,
                         input logic c_err, output int hi, output int per);
    logic prev, cur;
    int n;
    hi = 0; per = 0; n = 0;
    if (!at_rise) begin
      prev = pin();
      cur = prev;
      while (!(!prev && cur) && n < LIM) begin
        prev = cur;
        @(negedge clk_i); cur = pin(); n++;
      end
    end
    cur = 1'b1;
    while (cur && per < LIM) begin
      hi++; per++;
      if (hi == chg_at) begin angle_i = c_ang; err_i = c_err; end
      @(negedge clk_i); cur = pin();
    end
    while (!cur && per < LIM) begin
      per++;
      @(negedge clk_i); cur = pin();
    end
  endtask

  task automatic t_reset();
    pwm_en_i = 1'b1; pwm_sel_i = 1'b0; idx_func_i = 1'b1; w_func_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check(w_o == 1'b0, "R8 frame low in reset", w_o, 0);
    check(i_o == 1'b1, "R8 I pin passes index in reset", i_o, 1);
    pwm_en_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_normal();
    int hi, per;
    start_frame(1'b0, 12'd1000, 1'b0);
    idx_func_i = 1'b0;
    @(negedge clk_i);
    check(i_o == 1'b0, "R6 I pin follows index", i_o, 0);
    idx_func_i = 1'b1;
    @(negedge clk_i);
    check(i_o == 1'b1, "R6 I pin follows index", i_o, 1);
    measure(1'b0, -1, '0, 1'b0, hi, per);
    check(hi == (16 + 1000) * DIV, "R2 high time angle 1000", hi, (16 + 1000) * DIV);
    check(per == PER, "R1 frame period", per, PER);
    measure(1'b1, -1, '0, 1'b0, hi, per);
    check(per == PER, "R1 back-to-back period", per, PER);
  endtask

  task automatic t_extremes();
    int hi, per;
    start_frame(1'b0, 12'd0, 1'b0);
    measure(1'b1, -1, '0, 1'b0, hi, per);
    check(hi == 16 * DIV, "R9 angle 0 high", hi, 16 * DIV);
    check(per == PER, "R9 angle 0 period", per, PER);
    start_frame(1'b0, 12'd4095, 1'b0);
    measure(1'b1, -1, '0, 1'b0, hi, per);
    check(hi == 4111 * DIV, "R9 angle 4095 high", hi, 4111 * DIV);
    check(per - hi == 8 * DIV, "R9 angle 4095 tail", per - hi, 8 * DIV);
  endtask

  task automatic t_error();
    int hi, per;
    start_frame(1'b0, 12'd2000, 1'b1);
    measure(1'b1, -1, '0, 1'b1, hi, per);
    check(hi == 12 * DIV, "R3 error frame high", hi, 12 * DIV);
    check(per == PER, "R3 error frame period", per, PER);
  endtask

  task automatic t_sample();
    int hi, per;
    start_frame(1'b0, 12'd100, 1'b0);
    measure(1'b1, 10, 12'd3000, 1'b0, hi, per);
    check(hi == 116 * DIV, "R4 mid-frame angle change ignored", hi, 116 * DIV);
    measure(1'b1, 10, 12'd3000, 1'b1, hi, per);
    check(hi == 3016 * DIV, "R4 new angle next frame, error held", hi, 3016 * DIV);
    measure(1'b1, -1, '0, 1'b1, hi, per);
    check(hi == 12 * DIV, "R4 error applied next frame", hi, 12 * DIV);
  endtask

  task automatic t_sel_i();
    int hi, per;
    start_frame(1'b1, 12'd500, 1'b0);
    w_func_i = 1'b0;
    @(negedge clk_i);
    check(w_o == 1'b0, "R6 W pin follows function", w_o, 0);
    w_func_i = 1'b1;
    @(negedge clk_i);
    check(w_o == 1'b1, "R6 W pin follows function", w_o, 1);
    measure(1'b0, -1, '0, 1'b0, hi, per);
    check(hi == 516 * DIV, "R6 frame on I pin", hi, 516 * DIV);
  endtask

  task automatic t_disable();
    int errs = 0;
    start_frame(1'b0, 12'd3000, 1'b0);
    repeat (100) @(negedge clk_i);
    pwm_en_i = 1'b0; w_func_i = 1'b0; idx_func_i = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (w_o != w_func_i || i_o != idx_func_i) errs++;
      if (k == 100) begin w_func_i = 1'b1; idx_func_i = 1'b1; end
    end
    check(errs == 0, "R5 pins pass through while disabled", errs, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_normal();
    t_extremes();
    t_error();
    t_sample();
    t_sel_i();
    t_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule